// File: doc/BRIEF.md
# DMA Channel Bytecode Sequencer

This block is one DMA channel that runs a small byte-coded program instead of a fixed copy descriptor. On a start pulse it loads its program counter from the given start address. It then fetches instructions one byte at a time from a byte-wide program memory with one cycle of read latency, and executes each instruction once all of its bytes have arrived. Instructions are between one and six bytes long.

The instruction set covers the following:
- Loading the source address, destination address and channel-control registers from 32-bit immediates.
- Two loop counters that can be nested, with backward-jump loop ends.
- Burst loads and stores issued to a simple data port. Each access completes later through a per-type completion strobe.
- Read and write barriers that wait for those completions.
- Waiting on a peripheral request line.
- A peripheral flush pulse and an event pulse.
- Ending the program.

An opcode that is not defined stops the channel and raises a fault flag.

The block is meant to be driven by software that writes a channel program into memory shared with the sequencer and then starts it. The event output can feed an interrupt controller. The peripheral lines connect to request and flush wires of on-chip peripherals.

Top module: `dma_prog_seq`

## Requirements
- R1: After reset `busy`, `done`, `fault` and all output pulses are 0. A `start` pulse while idle loads the program counter from `start_addr`, sets `busy` and clears `fault`. A `start` pulse while busy is ignored.
- R2: The defined first bytes are 0x00, 0x04, 0x08, 0x12, 0x13, 0x20, 0x22, 0x30, 0x34, 0x35, 0x38, 0x3C and 0xBC. Any other first byte sets `fault`, drops `busy` and gives no `done`. `fault` stays set until the next accepted `start`.
- R3: Opcode 0xBC is six bytes long: the opcode, a select byte, then a 32-bit value with its least significant byte first. Select 0 writes the source address, 1 writes the control word and 2 writes the destination address. Any other select value raises `fault`.
- R4: A load (0x04) pulses `mem_ld` with `mem_addr` equal to the source address. A store (0x08) pulses `mem_st` with `mem_addr` equal to the destination address. The control word fields are:
  - source side: bit 0 increment, bits [3:1] size, bits [7:4] length;
  - destination side: bit 14 increment, bits [17:15] size, bits [21:18] length.
  After each access, the address on that side advances by (length+1)·2^size bytes when its increment bit is 1. When the bit is 0 the address is unchanged.
- R5: Loop start is 0x20 (counter 0) or 0x22 (counter 1), followed by a count byte N. The loop body runs N+1 times, from 1 to 256.
- R6: Loop end is 0x38 (counter 0) or 0x3C (counter 1), followed by a distance byte D, which is the number of bytes from the first body byte to the loop-end opcode. When the counter is nonzero, execution jumps back D bytes and the counter decrements. When the counter is zero, execution falls through. Counter 1 may enclose counter 0.
- R7: The read barrier (0x12) stalls until every issued load has been completed by `ld_done`. The write barrier (0x13) does the same for stores and `st_done`.
- R8: At most OUT_MAX loads and at most OUT_MAX stores may be outstanding. A further load or store waits until a completion arrives.
- R9: Wait-for-peripheral (0x30, then a byte whose bits [7:3] hold n) stalls until `periph_req[n]` is 1. Request lines other than n have no effect.
- R10: Flush (0x35) pulses `flush_valid` for one cycle with `flush_num` taken from bits [7:3] of its second byte. Send-event (0x34) does the same with `evt_valid` and `evt_num`.
- R11: End (0x00) pulses `done` for one cycle and clears `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted when idle |
| start_addr | input | PA_W | Program start address |
| pm_en | output | 1 | Program memory read enable |
| pm_addr | output | PA_W | Program memory byte address |
| pm_rdata | input | 8 | Program byte, valid one cycle after `pm_en` |
| mem_ld | output | 1 | Burst load issue pulse |
| mem_st | output | 1 | Burst store issue pulse |
| mem_addr | output | AW | Burst address |
| mem_size | output | 3 | Beat size exponent of the burst |
| mem_len | output | 4 | Beats minus one of the burst |
| ld_done | input | 1 | One load has completed |
| st_done | input | 1 | One store has completed |
| periph_req | input | 32 | Peripheral request lines |
| flush_valid | output | 1 | Peripheral flush pulse |
| flush_num | output | 5 | Peripheral being flushed |
| evt_valid | output | 1 | Event pulse |
| evt_num | output | 5 | Event number |
| busy | output | 1 | Program running |
| done | output | 1 | Program ended normally |
| fault | output | 1 | Undefined opcode or move select seen |

## Verification
The bench builds the block with OUT_MAX = 2, so three back-to-back loads hit the outstanding limit while completions are held back. The default PA_W of 8 gives a 256-byte program space that holds every test program at once. With these values, a loop count of 255 exercises the 256-iteration upper bound in a few thousand cycles. A zero loop count exercises the single-pass fall-through.

// File: rtl/dps_pkg.sv
package dps_pkg;
  localparam int NUM_W = 5;
  localparam int PER_N = 1 << NUM_W;

  localparam logic [7:0] OP_END   = 8'h00;
  localparam logic [7:0] OP_LD    = 8'h04;
  localparam logic [7:0] OP_ST    = 8'h08;
  localparam logic [7:0] OP_RMB   = 8'h12;
  localparam logic [7:0] OP_WMB   = 8'h13;
  localparam logic [7:0] OP_LP0   = 8'h20;
  localparam logic [7:0] OP_LP1   = 8'h22;
  localparam logic [7:0] OP_WFP   = 8'h30;
  localparam logic [7:0] OP_SEV   = 8'h34;
  localparam logic [7:0] OP_FLUSH = 8'h35;
  localparam logic [7:0] OP_LE0   = 8'h38;
  localparam logic [7:0] OP_LE1   = 8'h3C;
  localparam logic [7:0] OP_MOV   = 8'hBC;

  // control word field positions
  localparam int C_SINC = 0;
  localparam int C_SSZ  = 1;
  localparam int C_SLEN = 4;
  localparam int C_DINC = 14;
  localparam int C_DSZ  = 15;
  localparam int C_DLEN = 18;

  typedef enum logic [3:0] {
    K_END, K_MOV, K_LP, K_LPEND, K_LD, K_ST, K_RMB, K_WMB,
    K_WFP, K_FLUSH, K_SEV, K_BAD
  } op_kind_e;
endpackage

// File: rtl/dps_decode.sv
module dps_decode
  import dps_pkg::*;
(
  input  logic [7:0] op,
  output op_kind_e   kind,
  output logic [2:0] len,
  output logic       sel
);
  always_comb begin
    kind = K_BAD;
    len  = 3'd1;
    sel  = 1'b0;
    case (op)
      OP_END:   kind = K_END;
      OP_LD:    kind = K_LD;
      OP_ST:    kind = K_ST;
      OP_RMB:   kind = K_RMB;
      OP_WMB:   kind = K_WMB;
      OP_LP0, OP_LP1: begin kind = K_LP; len = 3'd2; sel = op[1]; end
      OP_LE0, OP_LE1: begin kind = K_LPEND; len = 3'd2; sel = op[2]; end
      OP_WFP:   begin kind = K_WFP;   len = 3'd2; end
      OP_SEV:   begin kind = K_SEV;   len = 3'd2; end
      OP_FLUSH: begin kind = K_FLUSH; len = 3'd2; end
      OP_MOV:   begin kind = K_MOV;   len = 3'd6; end
      default:  kind = K_BAD;
    endcase
  end
endmodule

// File: rtl/dps_pending.sv
module dps_pending #(
  parameter int MAX = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic issue,
  input  logic retire,
  output logic full,
  output logic empty
);
  localparam int CW = $clog2(MAX + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (issue && !retire) cnt <= cnt + 1'b1;
    else if (retire && !issue && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign full  = (cnt == CW'(MAX));
  assign empty = (cnt == '0);
endmodule

// File: rtl/dps_loopctr.sv
module dps_loopctr #(
  parameter int N = 2,
  parameter int W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       load,
  input  logic                       dec,
  input  logic [((N>1)?$clog2(N):1)-1:0] sel,
  input  logic [W-1:0]               val,
  output logic [N-1:0]               zero
);
  localparam int SW = (N > 1) ? $clog2(N) : 1;

  for (genvar g = 0; g < N; g++) begin : g_ctr
    logic [W-1:0] cnt;
    always_ff @(posedge clk) begin
      if (rst) cnt <= '0;
      else if (load && sel == SW'(g)) cnt <= val;
      else if (dec && sel == SW'(g)) cnt <= cnt - 1'b1;
    end
    assign zero[g] = (cnt == '0);
  end
endmodule

// File: rtl/dma_prog_seq.sv
module dma_prog_seq
  import dps_pkg::*;
#(
  parameter int PA_W    = 8,
  parameter int AW      = 32,
  parameter int OUT_MAX = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [PA_W-1:0]   start_addr,
  output logic              pm_en,
  output logic [PA_W-1:0]   pm_addr,
  input  logic [7:0]        pm_rdata,
  output logic              mem_ld,
  output logic              mem_st,
  output logic [AW-1:0]     mem_addr,
  output logic [2:0]        mem_size,
  output logic [3:0]        mem_len,
  input  logic              ld_done,
  input  logic              st_done,
  input  logic [PER_N-1:0]  periph_req,
  output logic              flush_valid,
  output logic [NUM_W-1:0]  flush_num,
  output logic              evt_valid,
  output logic [NUM_W-1:0]  evt_num,
  output logic              busy,
  output logic              done,
  output logic              fault
);
  localparam int IB_N = 6;

  typedef enum logic [2:0] {S_IDLE, S_ISSUE, S_WAIT, S_CAP, S_EXEC} st_e;
  st_e state;

  logic [PA_W-1:0] pc;
  logic [7:0]      ibuf [IB_N];
  logic [2:0]      nb, need, tot;
  logic [AW-1:0]   sar, dar;
  logic [31:0]     ccr;

  op_kind_e   kind;
  logic [2:0] dlen;
  logic       dsel;
  logic [7:0] dec_in;

  assign dec_in = (state == S_CAP) ? pm_rdata : ibuf[0];

  dps_decode u_dec (.op(dec_in), .kind(kind), .len(dlen), .sel(dsel));

  logic            exec, adv, mov_bad;
  logic [NUM_W-1:0] fnum;
  logic [31:0]     mv;
  logic [AW-1:0]   src_step, dst_step;
  logic            ld_full, ld_empty, st_full, st_empty;
  logic [1:0]      lc_zero;
  logic            ld_go, st_go, lc_load, lc_dec;

  assign exec     = (state == S_EXEC);
  assign fnum     = ibuf[1][7:3];
  assign mv       = {ibuf[5], ibuf[4], ibuf[3], ibuf[2]};
  assign mov_bad  = (kind == K_MOV) && (ibuf[1] > 8'd2);
  assign src_step = (AW'(ccr[C_SLEN +: 4]) + AW'(1)) << ccr[C_SSZ +: 3];
  assign dst_step = (AW'(ccr[C_DLEN +: 4]) + AW'(1)) << ccr[C_DSZ +: 3];
  assign tot      = (nb == 3'd0) ? dlen : need;

  assign ld_go   = exec && kind == K_LD && !ld_full;
  assign st_go   = exec && kind == K_ST && !st_full;
  assign lc_load = exec && kind == K_LP;
  assign lc_dec  = exec && kind == K_LPEND && !lc_zero[dsel];

  always_comb begin
    case (kind)
      K_LD:    adv = !ld_full;
      K_ST:    adv = !st_full;
      K_RMB:   adv = ld_empty;
      K_WMB:   adv = st_empty;
      K_WFP:   adv = periph_req[fnum];
      default: adv = 1'b1;
    endcase
  end

  dps_pending #(.MAX(OUT_MAX)) u_ldq (
    .clk(clk), .rst(rst), .issue(ld_go), .retire(ld_done),
    .full(ld_full), .empty(ld_empty));

  dps_pending #(.MAX(OUT_MAX)) u_stq (
    .clk(clk), .rst(rst), .issue(st_go), .retire(st_done),
    .full(st_full), .empty(st_empty));

  dps_loopctr #(.N(2), .W(8)) u_lc (
    .clk(clk), .rst(rst), .load(lc_load), .dec(lc_dec),
    .sel(dsel), .val(ibuf[1]), .zero(lc_zero));

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      pc <= '0; nb <= '0; need <= '0;
      sar <= '0; dar <= '0; ccr <= '0;
      for (int i = 0; i < IB_N; i++) ibuf[i] <= '0;
      busy <= 1'b0; done <= 1'b0; fault <= 1'b0;
      pm_en <= 1'b0; pm_addr <= '0;
      mem_ld <= 1'b0; mem_st <= 1'b0; mem_addr <= '0;
      mem_size <= '0; mem_len <= '0;
      flush_valid <= 1'b0; flush_num <= '0;
      evt_valid <= 1'b0; evt_num <= '0;
    end else begin
      done <= 1'b0; pm_en <= 1'b0;
      mem_ld <= 1'b0; mem_st <= 1'b0;
      flush_valid <= 1'b0; evt_valid <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            pc    <= start_addr;
            busy  <= 1'b1;
            fault <= 1'b0;
            nb    <= '0;
            state <= S_ISSUE;
          end
        end
        S_ISSUE: begin
          pm_en   <= 1'b1;
          pm_addr <= pc;
          state   <= S_WAIT;
        end
        S_WAIT: state <= S_CAP;
        S_CAP: begin
          ibuf[nb] <= pm_rdata;
          pc       <= pc + 1'b1;
          if (nb == 3'd0) need <= dlen;
          if (nb == 3'd0 && kind == K_BAD) begin
            fault <= 1'b1;
            busy  <= 1'b0;
            state <= S_IDLE;
          end else if (nb + 3'd1 == tot) begin
            nb    <= '0;
            state <= S_EXEC;
          end else begin
            nb    <= nb + 3'd1;
            state <= S_ISSUE;
          end
        end
        S_EXEC: begin
          case (kind)
            K_END: begin
              done <= 1'b1;
              busy <= 1'b0;
            end
            K_MOV: begin
              case (ibuf[1])
                8'd0: sar <= AW'(mv);
                8'd1: ccr <= mv;
                8'd2: dar <= AW'(mv);
                default: begin
                  fault <= 1'b1;
                  busy  <= 1'b0;
                end
              endcase
            end
            K_LPEND: if (!lc_zero[dsel]) pc <= pc - PA_W'(2) - PA_W'(ibuf[1]);
            K_LD: if (!ld_full) begin
              mem_ld   <= 1'b1;
              mem_addr <= sar;
              mem_size <= ccr[C_SSZ +: 3];
              mem_len  <= ccr[C_SLEN +: 4];
              if (ccr[C_SINC]) sar <= sar + src_step;
            end
            K_ST: if (!st_full) begin
              mem_st   <= 1'b1;
              mem_addr <= dar;
              mem_size <= ccr[C_DSZ +: 3];
              mem_len  <= ccr[C_DLEN +: 4];
              if (ccr[C_DINC]) dar <= dar + dst_step;
            end
            K_FLUSH: begin
              flush_valid <= 1'b1;
              flush_num   <= fnum;
            end
            K_SEV: begin
              evt_valid <= 1'b1;
              evt_num   <= fnum;
            end
            default: ;
          endcase
          if (kind == K_END || mov_bad) state <= S_IDLE;
          else if (adv) state <= S_ISSUE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dps_chk.sv
module dps_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic busy,
  input logic done,
  input logic fault,
  input logic mem_ld,
  input logic mem_st,
  input logic evt_valid,
  input logic flush_valid
);
  assert_start_accept_R1: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  assert_fault_stops_R2: assert property (@(posedge clk) disable iff (rst)
    fault |-> !busy);

  assert_fault_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    (fault && !start) |=> fault);

  assert_one_action_R4: assert property (@(posedge clk) disable iff (rst)
    $countones({mem_ld, mem_st, evt_valid, flush_valid}) <= 1);

  assert_pulse_in_run_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_ld || mem_st || evt_valid || flush_valid) |-> busy);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R11: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !fault));
endmodule

bind dma_prog_seq dps_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .fault(fault), .mem_ld(mem_ld), .mem_st(mem_st),
  .evt_valid(evt_valid), .flush_valid(flush_valid));

// File: tb/sim_dma_prog_seq.sv
`timescale 1ns/1ps
module sim_dma_prog_seq;
  localparam int PA_W = 8;
  localparam int AW   = 32;
  localparam int OUTQ = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, start, pm_en, mem_ld, mem_st, ld_done, st_done;
  logic flush_valid, evt_valid, busy, done, fault;
  logic [PA_W-1:0] start_addr, pm_addr;
  logic [7:0] pm_rdata;
  logic [AW-1:0] mem_addr;
  logic [2:0] mem_size;
  logic [3:0] mem_len;
  logic [31:0] periph_req;
  logic [4:0] flush_num, evt_num;

  dma_prog_seq #(.PA_W(PA_W), .AW(AW), .OUT_MAX(OUTQ)) u0 (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .pm_en(pm_en), .pm_addr(pm_addr), .pm_rdata(pm_rdata),
    .mem_ld(mem_ld), .mem_st(mem_st), .mem_addr(mem_addr),
    .mem_size(mem_size), .mem_len(mem_len),
    .ld_done(ld_done), .st_done(st_done), .periph_req(periph_req),
    .flush_valid(flush_valid), .flush_num(flush_num),
    .evt_valid(evt_valid), .evt_num(evt_num),
    .busy(busy), .done(done), .fault(fault));

  logic [7:0] pmem [256];
  always @(posedge clk) pm_rdata <= pmem[pm_addr];

  int n_chk = 0, n_fail = 0;
  int exp_k[$];
  longint exp_v[$];
  string exp_t[$];
  int ld_seen = 0, ld_pend = 0, st_pend = 0;
  bit ack_en = 1'b1, done_seen = 1'b0;
  int cur;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic push(input int k, input longint v, input string t);
    exp_k.push_back(k); exp_v.push_back(v); exp_t.push_back(t);
  endtask

  task automatic take(input int k, input longint v);
    int ek; longint ev; string et;
    if (exp_k.size() == 0) begin
      chk(1'b0, "R4", "unexpected output kind", k, 0);
    end else begin
      ek = exp_k.pop_front(); ev = exp_v.pop_front(); et = exp_t.pop_front();
      chk(ek == k, et, "output kind", k, ek);
      chk(ev == v, et, "output value", v, ev);
    end
  endtask

  // monitor and completion responder
  always @(negedge clk) begin
    if (rst) begin
      ld_done = 1'b0; st_done = 1'b0; ld_pend = 0; st_pend = 0;
    end else begin
      if (done) done_seen = 1'b1;
      if (mem_ld) begin ld_seen++; ld_pend++; take(1, longint'(mem_addr)); end
      if (mem_st) begin st_pend++; take(2, longint'(mem_addr)); end
      if (evt_valid) take(3, longint'(evt_num));
      if (flush_valid) take(4, longint'(flush_num));
      ld_done = ack_en && ld_pend > 0;
      if (ld_done) ld_pend--;
      st_done = ack_en && st_pend > 0;
      if (st_done) st_pend--;
    end
  end

  task automatic put(input logic [7:0] b);
    pmem[cur[7:0]] = b; cur++;
  endtask
  task automatic e_mov(input logic [7:0] s, input logic [31:0] v);
    put(8'hBC); put(s); put(v[7:0]); put(v[15:8]); put(v[23:16]); put(v[31:24]);
  endtask
  task automatic e_two(input logic [7:0] op, input logic [7:0] b);
    put(op); put(b);
  endtask

  task automatic go(input logic [7:0] a);
    @(negedge clk); start_addr = a; start = 1'b1; done_seen = 1'b0;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_end(input string tag);
    int n = 0;
    while (!(done_seen || fault) && n < 20000) begin @(negedge clk); n++; end
    chk(n < 20000, tag, "program did not end", n, 0);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    summary();
  end

  initial begin
    for (int i = 0; i < 256; i++) pmem[i] = 8'hFF;
    rst = 1'b1; start = 1'b0; start_addr = '0; periph_req = '0;
    ld_done = 1'b0; st_done = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !fault, "R1", "reset busy/done/fault", {busy, done, fault}, 0);
    chk(!mem_ld && !mem_st && !evt_valid && !flush_valid, "R1", "reset pulses",
        {mem_ld, mem_st, evt_valid, flush_valid}, 0);

    // A: nested loops, moves, incrementing bursts, flush, event
    cur = 8'h00;
    e_mov(8'd0, 32'h1000); e_mov(8'd2, 32'h2000); e_mov(8'd1, 32'h0005_4015);
    e_two(8'h22, 8'd1); e_two(8'h20, 8'd2);
    put(8'h04); put(8'h12); put(8'h08); put(8'h13);
    e_two(8'h38, 8'd4); e_two(8'h3C, 8'd8);
    e_two(8'h35, 8'd4 << 3); e_two(8'h34, 8'd5 << 3); put(8'h00);
    for (int k = 0; k < 6; k++) begin
      push(1, 32'h1000 + 8 * k, "R5_R6_R4 load addr");
      push(2, 32'h2000 + 8 * k, "R5_R6_R4 store addr");
    end
    push(4, 4, "R10 flush num"); push(3, 5, "R10 event num");
    go(8'h00);
    chk(busy && !fault, "R1", "busy after start", busy, 1);
    wait_end("R11");
    @(negedge clk);
    chk(done_seen && !busy, "R11", "done and idle", {done_seen, busy}, 2);
    chk(exp_k.size() == 0, "R6", "items left after nested loops", exp_k.size(), 0);

    // B: no-increment source, zero count, 256 iterations
    cur = 8'h30;
    e_mov(8'd0, 32'h300); e_mov(8'd2, 32'h400); e_mov(8'd1, 32'h0000_4000);
    e_two(8'h20, 8'd0); put(8'h04); put(8'h08); e_two(8'h38, 8'd2);
    put(8'h04); put(8'h08);
    e_two(8'h22, 8'd255); e_two(8'h34, 8'd7 << 3); e_two(8'h3C, 8'd2);
    put(8'h00);
    push(1, 32'h300, "R4 fixed src"); push(2, 32'h400, "R5 zero count store");
    push(1, 32'h300, "R4 fixed src again"); push(2, 32'h401, "R4 dst step 1");
    for (int k = 0; k < 256; k++) push(3, 7, "R5 256 iterations");
    go(8'h30);
    wait_end("R5");
    @(negedge clk);
    chk(exp_k.size() == 0, "R5", "items left after 256 loop", exp_k.size(), 0);

    // C: outstanding limit and read barrier, start while busy ignored
    cur = 8'h80;
    e_mov(8'd0, 32'h500); put(8'h04); put(8'h04); put(8'h04); put(8'h12);
    e_two(8'h34, 8'd1 << 3); put(8'h00);
    for (int k = 0; k < 3; k++) push(1, 32'h500, "R8 load");
    push(3, 1, "R7 event after barrier");
    ack_en = 1'b0; ld_seen = 0;
    go(8'h80);
    repeat (40) @(negedge clk);
    chk(ld_seen == 2, "R8", "loads issued with no completions", ld_seen, 2);
    chk(exp_k.size() == 2, "R7", "items pending at read barrier", exp_k.size(), 2);
    start_addr = 8'hF0; start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (5) @(negedge clk);
    chk(busy && !fault, "R1", "start while busy ignored", {busy, fault}, 2);
    ack_en = 1'b1;
    wait_end("R7");
    @(negedge clk);
    chk(exp_k.size() == 0 && !fault, "R7", "read barrier release", exp_k.size(), 0);

    // C2: write barrier
    cur = 8'hA0;
    e_mov(8'd2, 32'h600); put(8'h08); put(8'h13); e_two(8'h34, 8'd2 << 3); put(8'h00);
    push(2, 32'h600, "R7 store"); push(3, 2, "R7 event after write barrier");
    ack_en = 1'b0;
    go(8'hA0);
    repeat (30) @(negedge clk);
    chk(exp_k.size() == 1, "R7", "items pending at write barrier", exp_k.size(), 1);
    ack_en = 1'b1;
    wait_end("R7");
    @(negedge clk);
    chk(exp_k.size() == 0, "R7", "write barrier release", exp_k.size(), 0);

    // D: wait for peripheral
    cur = 8'hB0;
    e_two(8'h30, 8'd3 << 3); e_two(8'h35, 8'd6 << 3); put(8'h00);
    push(4, 6, "R9 flush after wait");
    periph_req = 32'h0000_0004;
    go(8'hB0);
    repeat (30) @(negedge clk);
    chk(exp_k.size() == 1 && busy, "R9", "other request line ignored", exp_k.size(), 1);
    periph_req = 32'h0000_0008;
    wait_end("R9");
    @(negedge clk);
    chk(exp_k.size() == 0, "R9", "wait released", exp_k.size(), 0);
    periph_req = '0;

    // E: undefined opcode, bad move select, fault cleared by start
    pmem[8'hF0] = 8'hFF;
    go(8'hF0);
    wait_end("R2");
    @(negedge clk);
    chk(fault && !busy && !done_seen, "R2", "undefined opcode fault",
        {fault, busy, done_seen}, 4);
    repeat (5) @(negedge clk);
    chk(fault, "R2", "fault sticky", fault, 1);
    cur = 8'h60;
    e_two(8'h34, 8'd9 << 3); put(8'h00);
    push(3, 9, "R2 run after fault");
    go(8'h60);
    chk(!fault && busy, "R2", "fault cleared by start", fault, 0);
    wait_end("R2");
    @(negedge clk);
    chk(exp_k.size() == 0, "R2", "program after fault", exp_k.size(), 0);
    cur = 8'hE0;
    e_mov(8'd3, 32'h1234); put(8'h00);
    go(8'hE0);
    wait_end("R3");
    @(negedge clk);
    chk(fault && !done_seen, "R3", "bad move select fault", {fault, done_seen}, 2);

    summary();
  end
endmodule